// File: doc/BRIEF.md
# SPI ADC single-conversion controller

This block sits on the host side of a serial link to an external multichannel analog-to-digital converter and performs one on-demand conversion per request. A request names a channel and says whether the internal temperature sensor is wanted instead of a voltage input. The controller then runs a fixed sequence over SPI. It sends a setup command that makes the converter start on the next conversion command, and then the conversion command itself. Next it waits a fixed settling time, because the converter's end-of-conversion signal is not reliable in this start mode. Last, it reads the result burst and returns the decoded code with a one-cycle done strobe.

The SPI side runs in mode 0 with one byte per shift and a clock divider set by a parameter. Chip select frames each command byte separately and covers the whole read burst. If the system reports that a triggered scan owns the converter, the request completes at once with a busy flag and the link stays quiet. The settling time is a parameter that defaults to 1 ms at the given system clock and can be shortened for simulation.

Top module: `adc_single_read_ctrl`

## Requirements
- R1: The first chip-select frame of an accepted request carries one byte, 8'h68: setup register selected by bit 6, clock-mode field bits 5:4 = 2'b10, reference field bits 3:2 = 2'b10, other bits zero.
- R2: The second frame carries one byte {1'b1, channel[3:0], 2'b11, temp}: bit 7 selects the conversion register, bits 6:3 hold the channel, bits 2:1 = 2'b11 mean no scan, bit 0 is 1 only for a temperature request.
- R3: Chip select is low for each command byte and the read burst, and stays high for at least 2*CLK_DIV system clock cycles (one SCLK period) between frames.
- R4: Chip select stays high for at least SETTLE_CYCLES system clock cycles between the end of the conversion frame and the start of the read frame.
- R5: The read frame is 16 SCLK cycles long for a voltage request and 32 for a temperature request, and MOSI is held low during it.
- R6: For a voltage request, result_o equals bits 11:2 of the 16-bit word formed by the first two read bytes (first byte most significant), zero-extended.
- R7: For a temperature request, result_o equals bits 11:0 of that word.
- R8: A request accepted while scan_active_i is high gives done_o and busy_err_o high in the next cycle, with no chip-select activity; otherwise busy_err_o is low with done_o.
- R9: req_ready_o goes low in the cycle after acceptance and stays low until the cycle of the one-cycle done_o strobe.
- R10: SPI mode 0: SCLK idles low and is low whenever chip select is high; bytes go out MSB first, driven before the rising edge, and MISO is sampled on the rising edge.
- R11: After reset, cs_no is high, sclk_o is low, req_ready_o is high and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Conversion request |
| req_ready_o | output | 1 | Controller can accept a request |
| req_chan_i | input | 4 | Channel index |
| req_temp_i | input | 1 | Read the temperature sensor instead of a voltage channel |
| scan_active_i | input | 1 | A triggered scan owns the converter |
| done_o | output | 1 | One-cycle completion strobe |
| busy_err_o | output | 1 | Request rejected as busy, valid with done_o |
| result_o | output | 12 | Decoded conversion code, valid with done_o |
| sclk_o | output | 1 | SPI clock |
| cs_no | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data to the converter |
| miso_i | input | 1 | SPI data from the converter |

## Verification
The hardest thing to reach from the ports is the four-byte temperature burst: the converter keeps driving MISO across a byte boundary while chip select stays low, and only the first two bytes may reach the result. The bench's converter model counts SCLK falling edges from the chip-select fall and shifts a 32-bit response word continuously, so the trailing bytes carry data the decoder must drop. The frame monitor records each chip-select window, with its bit count, its first byte and the cycles of high chip select before it. The settling and gap bounds are then checked on the waveform the converter would actually see.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  localparam int unsigned CHAN_W = 4;
  localparam int unsigned RES_W  = 12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_GAP, ST_CONV, ST_SETTLE, ST_READ, ST_TAIL, ST_RESP
  } seq_state_e;

  // setup reg select, clock mode 2, reference mode 2
  localparam logic [7:0] SETUP_CMD = 8'h68;

  function automatic logic [7:0] conv_cmd(input logic [CHAN_W-1:0] chan, input logic temp);
    return {1'b1, chan, 2'b11, temp};
  endfunction

  function automatic logic [RES_W-1:0] decode_word(input logic [15:0] word, input logic temp);
    return temp ? word[11:0] : {2'b00, word[11:2]};
  endfunction

endpackage

// File: rtl/adc_spi_byte_master.sv
module adc_spi_byte_master #(
  parameter int unsigned DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       done_o,
  output logic       busy_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          active_q, sclk_q, done_q;
  logic [DW-1:0] div_q;
  logic [3:0]    edge_q;
  logic [7:0]    tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      div_q    <= '0;
      edge_q   <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !active_q) begin
        active_q <= 1'b1;
        tx_q     <= tx_i;
        div_q    <= '0;
        edge_q   <= '0;
        sclk_q   <= 1'b0;
      end else if (active_q) begin
        if (div_q == DW'(DIV - 1)) begin
          div_q  <= '0;
          sclk_q <= ~sclk_q;
          edge_q <= edge_q + 4'd1;
          if (!sclk_q) begin
            rx_q <= {rx_q[6:0], miso_i};
          end else begin
            tx_q <= {tx_q[6:0], 1'b0};
            if (edge_q == 4'd15) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
            end
          end
        end else begin
          div_q <= div_q + DW'(1);
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[7];
  assign rx_o   = rx_q;
  assign done_o = done_q;
  assign busy_o = active_q;

  // R10
  spi_start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q);
  // R10
  sclk_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !sclk_q);

endmodule

// File: rtl/adc_cycle_timer.sv
module adc_cycle_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] count_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= count_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign expired_o = (cnt_q == '0);

  // R4
  tmr_count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !expired_o) |=> (cnt_q == $past(cnt_q) - W'(1)));

endmodule

// File: rtl/adc_single_read_ctrl.sv
module adc_single_read_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned CLK_DIV       = 4,
  parameter int unsigned CLK_HZ        = 100_000_000,
  parameter int unsigned SETTLE_CYCLES = CLK_HZ / 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [CHAN_W-1:0] req_chan_i,
  input  logic              req_temp_i,
  input  logic              scan_active_i,
  output logic              done_o,
  output logic              busy_err_o,
  output logic [RES_W-1:0]  result_o,
  output logic              sclk_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int unsigned GAP_CYCLES = 2 * CLK_DIV;
  localparam int unsigned TMAX = (SETTLE_CYCLES > GAP_CYCLES) ? SETTLE_CYCLES : GAP_CYCLES;
  localparam int unsigned TW   = $clog2(TMAX + 1);

  seq_state_e        state_q;
  logic              cs_q, start_q, temp_q, busy_q;
  logic [CHAN_W-1:0] chan_q;
  logic [7:0]        tx_q;
  logic [1:0]        byte_q;
  logic [15:0]       word_q;
  logic [RES_W-1:0]  res_q;

  logic              spi_done, spi_busy, spi_mosi;
  logic [7:0]        spi_rx;
  logic              tmr_load, tmr_exp;
  logic [TW-1:0]     tmr_val;
  logic              last_byte, accept;

  adc_spi_byte_master #(.DIV(CLK_DIV)) u_spi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_q),
    .tx_i   (tx_q),
    .miso_i (miso_i),
    .sclk_o (sclk_o),
    .mosi_o (spi_mosi),
    .rx_o   (spi_rx),
    .done_o (spi_done),
    .busy_o (spi_busy)
  );

  adc_cycle_timer #(.W(TW)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .count_i  (tmr_val),
    .expired_o(tmr_exp)
  );

  assign accept    = req_valid_i && (state_q == ST_IDLE);
  assign last_byte = (byte_q == (temp_q ? 2'd3 : 2'd1));

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TW'(GAP_CYCLES);
    if (spi_done) begin
      unique case (state_q)
        ST_SETUP: tmr_load = 1'b1;
        ST_CONV: begin
          tmr_load = 1'b1;
          tmr_val  = TW'(SETTLE_CYCLES);
        end
        ST_READ:  tmr_load = last_byte;
        default:  tmr_load = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b1;
      start_q <= 1'b0;
      tx_q    <= '0;
      temp_q  <= 1'b0;
      busy_q  <= 1'b0;
      chan_q  <= '0;
      byte_q  <= '0;
      word_q  <= '0;
      res_q   <= '0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          chan_q <= req_chan_i;
          temp_q <= req_temp_i;
          busy_q <= scan_active_i;
          if (scan_active_i) begin
            res_q   <= '0;
            state_q <= ST_RESP;
          end else begin
            cs_q    <= 1'b0;
            start_q <= 1'b1;
            tx_q    <= SETUP_CMD;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP: if (spi_done) begin
          cs_q    <= 1'b1;
          state_q <= ST_GAP;
        end
        ST_GAP: if (tmr_exp) begin
          cs_q    <= 1'b0;
          start_q <= 1'b1;
          tx_q    <= conv_cmd(chan_q, temp_q);
          state_q <= ST_CONV;
        end
        ST_CONV: if (spi_done) begin
          cs_q    <= 1'b1;
          state_q <= ST_SETTLE;
        end
        ST_SETTLE: if (tmr_exp) begin
          cs_q    <= 1'b0;
          start_q <= 1'b1;
          tx_q    <= 8'h00;
          byte_q  <= '0;
          state_q <= ST_READ;
        end
        ST_READ: if (spi_done) begin
          if (byte_q == 2'd0) word_q[15:8] <= spi_rx;
          if (byte_q == 2'd1) word_q[7:0]  <= spi_rx;
          if (last_byte) begin
            cs_q    <= 1'b1;
            state_q <= ST_TAIL;
          end else begin
            byte_q  <= byte_q + 2'd1;
            start_q <= 1'b1;
          end
        end
        ST_TAIL: if (tmr_exp) begin
          res_q   <= decode_word(word_q, temp_q);
          state_q <= ST_RESP;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_RESP);
  assign busy_err_o  = done_o && busy_q;
  assign result_o    = res_q;
  assign cs_no       = cs_q;
  assign mosi_o      = spi_mosi;

  // R8
  busy_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && scan_active_i) |=> (done_o && busy_err_o && cs_no));
  // R10
  sclk_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  // R9
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  // R3
  cs_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |=> cs_no);
  // R3
  spi_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_busy |-> !cs_no);

endmodule

// File: tb/tb_adc_single_read_ctrl.sv
module tb_adc_single_read_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int SETTLE     = 40;
  localparam int NVEC       = 6;
  // {chan[3:0], temp, hi[7:0], lo[7:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {4'd0,  1'b0, 8'hFF, 8'hFC},
    {4'd5,  1'b0, 8'h12, 8'h34},
    {4'd15, 1'b0, 8'hA5, 8'h5A},
    {4'd0,  1'b1, 8'h0A, 8'hBC},
    {4'd3,  1'b1, 8'hF1, 8'h23},
    {4'd9,  1'b0, 8'h00, 8'h03}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_temp = 1'b0, scan_active = 1'b0;
  logic [3:0] req_chan = '0;
  logic req_ready, done, busy_err, sclk, cs_n, mosi, miso;
  logic [11:0] result;

  int nchk = 0, nfail = 0;
  logic [31:0] resp_word = '0;
  int fall_cnt = 0;

  int nfr = 0, bitcnt = 0, gap_cnt = 0, sclk_bad = 0, mosi_bad = 0;
  int fr_bits [128];
  int fr_gap  [128];
  logic [7:0] fr_byte0 [128];
  logic [7:0] sh8 = '0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_single_read_ctrl #(.CLK_DIV(DIV), .SETTLE_CYCLES(SETTLE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_chan_i(req_chan), .req_temp_i(req_temp), .scan_active_i(scan_active),
    .done_o(done), .busy_err_o(busy_err), .result_o(result),
    .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  // converter model: MISO shifts on SCLK falling edges from chip-select fall
  always @(negedge sclk or posedge cs_n) begin
    if (cs_n) fall_cnt <= 0;
    else      fall_cnt <= fall_cnt + 1;
  end
  assign miso = (fall_cnt < 32) ? resp_word[31 - fall_cnt] : 1'b0;

  // frame monitor
  always @(posedge clk) begin
    if (cs_n && sclk) sclk_bad <= sclk_bad + 1;
    if (prev_cs && !cs_n) begin
      fr_gap[nfr % 128] <= gap_cnt;
      gap_cnt <= 0;
      bitcnt  <= 0;
    end else if (cs_n) begin
      gap_cnt <= gap_cnt + 1;
    end
    if (!cs_n && !prev_sclk && sclk) begin
      sh8 <= {sh8[6:0], mosi};
      bitcnt <= bitcnt + 1;
      if (bitcnt == 7) fr_byte0[nfr % 128] <= {sh8[6:0], mosi};
      if (bitcnt >= 8 && mosi) mosi_bad <= mosi_bad + 1;
    end
    if (!prev_cs && cs_n) begin
      fr_bits[nfr % 128] <= bitcnt;
      nfr <= nfr + 1;
    end
    prev_cs   <= cs_n;
    prev_sclk <= sclk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_req(input logic [3:0] ch, input logic tmp, input logic scan,
                         input logic [7:0] hi, input logic [7:0] lo);
    int base, waited, ready_bad, mb;
    logic [15:0] word;
    logic [11:0] exp_res;
    base = nfr;
    mb = mosi_bad;
    ready_bad = 0;
    waited = 0;
    resp_word = {hi, lo, ~lo, ~hi};
    @(negedge clk);
    req_valid = 1'b1; req_chan = ch; req_temp = tmp; scan_active = scan;
    @(negedge clk);
    req_valid = 1'b0; scan_active = 1'b0;
    while (!done && waited < 20000) begin
      if (req_ready) ready_bad++;
      @(negedge clk);
      waited++;
    end
    check(waited < 20000, "R9 done reached", waited, 0);
    check(ready_bad == 0, "R9 ready low while busy", ready_bad, 0);
    if (scan) begin
      check(waited == 0, "R8 busy done next cycle", waited, 0);
      check(busy_err == 1'b1, "R8 busy flag", busy_err, 1);
      check(nfr == base && cs_n, "R8 no chip-select activity", nfr - base, 0);
    end else begin
      word = {hi, lo};
      exp_res = tmp ? word[11:0] : {2'b00, word[11:2]};
      check(busy_err == 1'b0, "R8 no busy", busy_err, 0);
      check(nfr - base == 3, "R3 frame count", nfr - base, 3);
      check(fr_bits[base % 128] == 8 && fr_byte0[base % 128] == 8'h68,
            "R1 setup byte", fr_byte0[base % 128], 8'h68);
      check(fr_bits[(base+1) % 128] == 8 && fr_byte0[(base+1) % 128] == {1'b1, ch, 2'b11, tmp},
            "R2 conversion byte", fr_byte0[(base+1) % 128], {1'b1, ch, 2'b11, tmp});
      check(fr_gap[(base+1) % 128] >= 2*DIV, "R3 gap between command frames",
            fr_gap[(base+1) % 128], 2*DIV);
      check(fr_gap[(base+2) % 128] >= SETTLE, "R4 settle before read",
            fr_gap[(base+2) % 128], SETTLE);
      check(fr_bits[(base+2) % 128] == (tmp ? 32 : 16), "R5 read length",
            fr_bits[(base+2) % 128], tmp ? 32 : 16);
      check(mosi_bad == mb, "R5 MOSI low during read", mosi_bad - mb, 0);
      if (tmp) check(result == exp_res, "R7 temperature result", result, exp_res);
      else     check(result == exp_res, "R6 voltage result", result, exp_res);
    end
    @(negedge clk);
    check(!done && req_ready, "R9 single-cycle done", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(cs_n == 1'b1, "R11 cs high", cs_n, 1);
    check(sclk == 1'b0, "R11 sclk low", sclk, 0);
    check(req_ready == 1'b1, "R11 ready", req_ready, 1);
    check(done == 1'b0, "R11 done low", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NVEC; i++)
      run_req(VEC[i][20:17], VEC[i][16], 1'b0, VEC[i][15:8], VEC[i][7:0]);
    // R8 triggered scan owns the converter
    run_req(4'd7, 1'b0, 1'b1, 8'h55, 8'hAA);
    // back-to-back after a reject, highest channel with temperature flag
    run_req(4'd15, 1'b1, 1'b0, 8'h7F, 8'hFF);
    // R10 no SCLK while chip select high
    check(sclk_bad == 0, "R10 sclk low outside frames", sclk_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

endmodule